// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block turns one PWM command into the high-side and low-side gate enables of a single synchronous buck half-bridge, and it never has both enables high in the same cycle. Two digitised comparator flags come from the analog side. One says the low-side gate voltage is below its turn-off level. The other says the switch node is below its low level. Each transition uses these flags to end the dead time as soon as the falling switch is really off. A gate turn-off is always held for a fixed propagation delay first.

There are two timed escapes. When the switch node does not fall after the high side turns off, the low side still turns on after a refresh timeout, so the bootstrap capacitor gets recharged. When the low side is on and the switch node stays high without a break for too long, the low side is cut off, so the low switch behaves like a diode. After that cutoff the bridge stays off until the next PWM rising edge. A supply-valid input keeps the bridge off while it is low.

The sequencer has seven states:
- IDLE (code 0)
- LS_TOFF (1): low-side turn-off delay
- WAIT_LS (2): waiting for the low-side gate to be low
- HS_ON (3)
- HS_TOFF (4): high-side turn-off delay
- WAIT_NODE (5): waiting for the switch node to be low
- LS_ON (6)

The transitions are:
- IDLE→WAIT_LS on a PWM rise.
- LS_ON→LS_TOFF on a PWM rise.
- LS_ON→IDLE on the diode cutoff.
- LS_TOFF→WAIT_LS when its delay expires.
- LS_TOFF→LS_ON on a PWM fall (abort).
- WAIT_LS→HS_ON when the gate-low flag is seen.
- WAIT_LS→WAIT_NODE on a PWM fall (abort).
- HS_ON→HS_TOFF on a PWM fall.
- HS_TOFF→WAIT_NODE when its delay expires.
- HS_TOFF→HS_ON on a PWM rise (abort).
- WAIT_NODE→LS_ON when the node-low flag is seen or the refresh timeout expires.
- WAIT_NODE→WAIT_LS on a PWM rise (abort).
- Any state→IDLE while the supply-valid input is low.

Top module: `deadtime_gate_seq`

## Requirements
- R1: While `supply_ok` is low, the state goes to IDLE and both enables are low from the next clock edge on, and PWM edges are ignored. When `supply_ok` returns with PWM already high, no rising edge is seen.
- R2: `hs_en` and `ls_en` are never both high in any cycle.
- R3: On a PWM rise seen in LS_ON, `ls_en` stays high for LS_TOFF cycles (2 with the default parameters) and then falls. `hs_en` rises only in the cycle after the synchronised gate-low flag is seen in WAIT_LS.
- R4: On a PWM fall seen in HS_ON, `hs_en` stays high for HS_TOFF cycles (3 with the default parameters) and then falls. `ls_en` rises when the synchronised node-low flag is seen in WAIT_NODE.
- R5: If the node-low flag is not seen, `ls_en` rises after REFRESH cycles in WAIT_NODE (25 with the default parameters).
- R6: In LS_ON, if the synchronised node-low flag stays low for DIODE consecutive cycles (200 with the default parameters), `ls_en` falls and the state goes to IDLE. Any cycle in which the flag is seen high restarts that count.
- R7: In IDLE, only a PWM rising edge starts a sequence. PWM falls and changes on either flag leave both enables low.
- R8: A PWM edge in the opposite direction during LS_TOFF, WAIT_LS, HS_TOFF or WAIT_NODE aborts the sequence. LS_TOFF returns to LS_ON and HS_TOFF returns to HS_ON. WAIT_LS goes to WAIT_NODE and WAIT_NODE goes to WAIT_LS, so no enable is raised early.
- R9: Both flags pass through a two-flop synchroniser. A flag change driven between clock edges therefore acts on the enables at the third rising edge after it.
- R10: `phase_code` shows the state with this encoding: IDLE=0, LS_TOFF=1, WAIT_LS=2, HS_ON=3, HS_TOFF=4, WAIT_NODE=5, LS_ON=6.
- R11: An asynchronous low on `rst_n` at once forces IDLE with both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok | input | 1 | Gate-drive supply valid; low keeps the bridge off |
| pwm_cmd | input | 1 | PWM command, synchronous to `clk` |
| lsg_low_raw | input | 1 | Comparator flag: low-side gate below its turn-off level |
| sw_low_raw | input | 1 | Comparator flag: switch node below its low level |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| phase_code | output | 3 | Current sequencer state (encoding in R10) |

## Verification
The assertions check four things on every cycle: that the two enables never overlap, that a low supply forces both enables off, that each enable rises only after the flag or timeout that allows it, and that IDLE holds the bridge off without a rising edge. Some behaviours show only in the bench's scenarios because they need exact cycle counts over a whole sequence:
- the exact lengths of the turn-off delays and the refresh timeout
- the restart of the diode-cutoff count
- the three-edge flag latency
- each abort path
- PWM being ignored while the supply is low

// File: rtl/gs_pkg.sv
package gs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LS_TOFF   = 3'd1,
        ST_WAIT_LS   = 3'd2,
        ST_HS_ON     = 3'd3,
        ST_HS_TOFF   = 3'd4,
        ST_WAIT_NODE = 3'd5,
        ST_LS_ON     = 3'd6
    } seq_state_e;

    // Round a time interval up to whole clock cycles, never below one.
    function automatic int ns_to_cycles(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/gs_flag_sync.sv
module gs_flag_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_out = stage_q[STAGES-1];

endmodule

// File: rtl/gs_span_timer.sv
module gs_span_timer #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_clr,
    output logic done
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (hold_clr)      cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + CW'(1);
    end

    assign done = (cnt_q == LAST);

    // R6
    span_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hold_clr) |=> done);

endmodule

// File: rtl/deadtime_gate_seq.sv
module deadtime_gate_seq
    import gs_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int LS_TOFF_NS    = 20,
    parameter int HS_TOFF_NS    = 30,
    parameter int REFRESH_NS    = 250,
    parameter int DIODE_NS      = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       supply_ok,
    input  logic       pwm_cmd,
    input  logic       lsg_low_raw,
    input  logic       sw_low_raw,
    output logic       hs_en,
    output logic       ls_en,
    output logic [2:0] phase_code
);

    localparam int LS_TOFF_CYC = ns_to_cycles(LS_TOFF_NS, CLK_PERIOD_NS);
    localparam int HS_TOFF_CYC = ns_to_cycles(HS_TOFF_NS, CLK_PERIOD_NS);
    localparam int REFRESH_CYC = ns_to_cycles(REFRESH_NS, CLK_PERIOD_NS);
    localparam int DIODE_CYC   = ns_to_cycles(DIODE_NS, CLK_PERIOD_NS);

    seq_state_e state_q, nxt;
    logic       pwm_q, pwm_rise, pwm_fall;
    logic [1:0] flags_s;
    logic       lsg_low_s, sw_low_s;
    logic       ls_toff_done, hs_toff_done, refresh_done, diode_done;

    // Comparator flags into the clock domain (R9)
    gs_flag_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({lsg_low_raw, sw_low_raw}),
        .q_out (flags_s)
    );
    assign lsg_low_s = flags_s[1];
    assign sw_low_s  = flags_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_cmd;
    end
    assign pwm_rise = pwm_cmd & ~pwm_q;
    assign pwm_fall = ~pwm_cmd & pwm_q;

    // Interval timers: each restarts whenever its qualifying condition lapses
    gs_span_timer #(.LIMIT(LS_TOFF_CYC)) u_ls_toff (
        .clk (clk), .rst_n (rst_n),
        .hold_clr (state_q != ST_LS_TOFF), .done (ls_toff_done)
    );
    gs_span_timer #(.LIMIT(HS_TOFF_CYC)) u_hs_toff (
        .clk (clk), .rst_n (rst_n),
        .hold_clr (state_q != ST_HS_TOFF), .done (hs_toff_done)
    );
    gs_span_timer #(.LIMIT(REFRESH_CYC)) u_refresh (
        .clk (clk), .rst_n (rst_n),
        .hold_clr (state_q != ST_WAIT_NODE), .done (refresh_done)
    );
    gs_span_timer #(.LIMIT(DIODE_CYC)) u_diode (
        .clk (clk), .rst_n (rst_n),
        .hold_clr ((state_q != ST_LS_ON) || sw_low_s), .done (diode_done)
    );

    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:      if (pwm_rise) nxt = ST_WAIT_LS;
            ST_LS_ON:     if (pwm_rise) nxt = ST_LS_TOFF;
                          else if (diode_done) nxt = ST_IDLE;
            ST_LS_TOFF:   if (pwm_fall) nxt = ST_LS_ON;
                          else if (ls_toff_done) nxt = ST_WAIT_LS;
            ST_WAIT_LS:   if (pwm_fall) nxt = ST_WAIT_NODE;
                          else if (lsg_low_s) nxt = ST_HS_ON;
            ST_HS_ON:     if (pwm_fall) nxt = ST_HS_TOFF;
            ST_HS_TOFF:   if (pwm_rise) nxt = ST_HS_ON;
                          else if (hs_toff_done) nxt = ST_WAIT_NODE;
            ST_WAIT_NODE: if (pwm_rise) nxt = ST_WAIT_LS;
                          else if (sw_low_s || refresh_done) nxt = ST_LS_ON;
            default:      nxt = ST_IDLE;
        endcase
        if (!supply_ok) nxt = ST_IDLE;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= nxt;
    end

    // Registered gate enables, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_en <= 1'b0;
            ls_en <= 1'b0;
        end else begin
            hs_en <= (nxt == ST_HS_ON) || (nxt == ST_HS_TOFF);
            ls_en <= (nxt == ST_LS_ON) || (nxt == ST_LS_TOFF);
        end
    end

    assign phase_code = state_q;

    // R2
    no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    // R1
    supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!hs_en && !ls_en));

    // R3
    hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> ($past(lsg_low_s) && !$past(ls_en)));

    // R4
    ls_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> (($past(sw_low_s) || $past(refresh_done)) && !$past(hs_en)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_code == 3'd0 && !pwm_rise) |=> (!hs_en && !ls_en));

endmodule

// File: tb/deadtime_gate_seq_tb_top.sv
module deadtime_gate_seq_tb_top;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NSTEPS = 40;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       supply_ok, pwm_cmd, lsg_low_raw, sw_low_raw;
    logic       hs_en, ls_en;
    logic [2:0] phase_code;

    int checks = 0;
    int errors = 0;
    int overlap_cnt = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    deadtime_gate_seq dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_ok   (supply_ok),
        .pwm_cmd     (pwm_cmd),
        .lsg_low_raw (lsg_low_raw),
        .sw_low_raw  (sw_low_raw),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .phase_code  (phase_code)
    );

    // Row: [31:28] requirement, [27:24] {pwm, gate-low flag, node-low flag, supply},
    // [23:8] clock edges to wait, [7] hs, [6] ls, [5:3] phase code.
    // Phase codes per R10: 0 IDLE, 1 LS_TOFF, 2 WAIT_LS, 3 HS_ON, 4 HS_TOFF, 5 WAIT_NODE, 6 LS_ON.
    localparam logic [31:0] STEPS [NSTEPS] = '{
        {4'd11, 4'b0111, 16'd5,   1'b0, 1'b0, 3'd0, 3'd0}, // R11 idle after reset
        {4'd3,  4'b1111, 16'd1,   1'b0, 1'b0, 3'd2, 3'd0}, // R3 rise from idle
        {4'd3,  4'b1111, 16'd1,   1'b1, 1'b0, 3'd3, 3'd0}, // R3 hs on
        {4'd4,  4'b0101, 16'd1,   1'b1, 1'b0, 3'd4, 3'd0}, // R4 hs turn-off delay
        {4'd4,  4'b0101, 16'd2,   1'b1, 1'b0, 3'd4, 3'd0}, // R4 delay still running
        {4'd4,  4'b0101, 16'd1,   1'b0, 1'b0, 3'd5, 3'd0}, // R4 wait for node
        {4'd9,  4'b0011, 16'd2,   1'b0, 1'b0, 3'd5, 3'd0}, // R9 flag not yet through
        {4'd4,  4'b0011, 16'd1,   1'b0, 1'b1, 3'd6, 3'd0}, // R4 ls on
        {4'd3,  4'b1011, 16'd1,   1'b0, 1'b1, 3'd1, 3'd0}, // R3 ls turn-off delay
        {4'd3,  4'b1011, 16'd1,   1'b0, 1'b1, 3'd1, 3'd0}, // R3 delay still running
        {4'd3,  4'b1011, 16'd1,   1'b0, 1'b0, 3'd2, 3'd0}, // R3 ls off, wait gate-low
        {4'd9,  4'b1101, 16'd2,   1'b0, 1'b0, 3'd2, 3'd0}, // R9 gate-low not yet through
        {4'd3,  4'b1101, 16'd1,   1'b1, 1'b0, 3'd3, 3'd0}, // R3 hs on after flag
        {4'd5,  4'b0101, 16'd28,  1'b0, 1'b0, 3'd5, 3'd0}, // R5 node stays high
        {4'd5,  4'b0101, 16'd1,   1'b0, 1'b1, 3'd6, 3'd0}, // R5 refresh timeout
        {4'd6,  4'b0101, 16'd198, 1'b0, 1'b1, 3'd6, 3'd0}, // R6 before cutoff
        {4'd6,  4'b0101, 16'd1,   1'b0, 1'b1, 3'd6, 3'd0}, // R6 last cycle
        {4'd6,  4'b0101, 16'd1,   1'b0, 1'b0, 3'd0, 3'd0}, // R6 cutoff
        {4'd7,  4'b0111, 16'd5,   1'b0, 1'b0, 3'd0, 3'd0}, // R7 node flag ignored in idle
        {4'd3,  4'b1111, 16'd1,   1'b0, 1'b0, 3'd2, 3'd0}, // R3 rise restarts
        {4'd3,  4'b1111, 16'd1,   1'b1, 1'b0, 3'd3, 3'd0}, // R3 hs on
        {4'd8,  4'b0111, 16'd1,   1'b1, 1'b0, 3'd4, 3'd0}, // R8 fall starts hs off
        {4'd8,  4'b1111, 16'd1,   1'b1, 1'b0, 3'd3, 3'd0}, // R8 abort back to hs on
        {4'd8,  4'b0101, 16'd4,   1'b0, 1'b0, 3'd5, 3'd0}, // R8 reach wait-node
        {4'd8,  4'b1101, 16'd1,   1'b0, 1'b0, 3'd2, 3'd0}, // R8 abort to wait-ls
        {4'd8,  4'b1101, 16'd1,   1'b1, 1'b0, 3'd3, 3'd0}, // R8 hs on
        {4'd4,  4'b0111, 16'd5,   1'b0, 1'b1, 3'd6, 3'd0}, // R4 fast node low
        {4'd8,  4'b1111, 16'd1,   1'b0, 1'b1, 3'd1, 3'd0}, // R8 rise starts ls off
        {4'd8,  4'b0111, 16'd1,   1'b0, 1'b1, 3'd6, 3'd0}, // R8 abort back to ls on
        {4'd6,  4'b0101, 16'd150, 1'b0, 1'b1, 3'd6, 3'd0}, // R6 partial high span
        {4'd6,  4'b0111, 16'd5,   1'b0, 1'b1, 3'd6, 3'd0}, // R6 node low restarts count
        {4'd6,  4'b0101, 16'd150, 1'b0, 1'b1, 3'd6, 3'd0}, // R6 no cutoff after restart
        {4'd1,  4'b0100, 16'd1,   1'b0, 1'b0, 3'd0, 3'd0}, // R1 supply drop
        {4'd1,  4'b1100, 16'd2,   1'b0, 1'b0, 3'd0, 3'd0}, // R1 rise ignored
        {4'd1,  4'b0100, 16'd2,   1'b0, 1'b0, 3'd0, 3'd0}, // R1 fall ignored
        {4'd1,  4'b1100, 16'd2,   1'b0, 1'b0, 3'd0, 3'd0}, // R1 rise ignored
        {4'd1,  4'b1101, 16'd3,   1'b0, 1'b0, 3'd0, 3'd0}, // R1 return with pwm high
        {4'd7,  4'b0101, 16'd1,   1'b0, 1'b0, 3'd0, 3'd0}, // R7 fall in idle
        {4'd1,  4'b1101, 16'd1,   1'b0, 1'b0, 3'd2, 3'd0}, // R1 fresh rise accepted
        {4'd3,  4'b1101, 16'd1,   1'b1, 1'b0, 3'd3, 3'd0}  // R3 hs on
    };

    task automatic check(input int req, input logic e_hs, input logic e_ls,
                         input logic [2:0] e_ph);
        checks++;
        if (hs_en !== e_hs || ls_en !== e_ls || phase_code !== e_ph) begin
            errors++;
            $display("FAIL R%0d: hs=%b ls=%b phase=%0d, expected hs=%b ls=%b phase=%0d",
                     req, hs_en, ls_en, phase_code, e_hs, e_ls, e_ph);
        end
    endtask

    always @(negedge clk) if (rst_n === 1'b1 && hs_en && ls_en) overlap_cnt++;

    initial begin
        rst_n = 1'b0;
        supply_ok = 1'b1; pwm_cmd = 1'b0; lsg_low_raw = 1'b1; sw_low_raw = 1'b1;
        repeat (3) @(negedge clk);
        check(11, 1'b0, 1'b0, 3'd0); // R11 during reset
        rst_n = 1'b1;
        for (int i = 0; i < NSTEPS; i++) begin
            logic [31:0] row;
            row = STEPS[i];
            {pwm_cmd, lsg_low_raw, sw_low_raw, supply_ok} = row[27:24];
            repeat (int'(row[23:8])) @(negedge clk);
            check(int'(row[31:28]), row[7], row[6], row[5:3]); // R10 phase each step
        end
        // R11 asynchronous reset mid-sequence (hs is on here)
        #1 rst_n = 1'b0;
        #1 check(11, 1'b0, 1'b0, 3'd0);
        // R2 no overlap seen over the whole run
        checks++;
        if (overlap_cnt != 0) begin
            errors++;
            $display("FAIL R2: overlap cycles=%0d, expected 0", overlap_cnt);
        end
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule